// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block is a small Moore state machine for a single-slot coin acceptor. The acceptor delivers a one-cycle pulse for each nickel (5 units) or dime (10 units) it takes in. The controller tracks the credit in four coded states: 0, 5, 10 and 15 units. It raises a release strobe for one cycle once the credit reaches 15 units.

No change is returned. A dime that would take the credit past 15 units lands in the 15-unit state, and the extra 5 units are dropped. The clock edge after a release brings the credit back to zero, so the next purchase starts clean.

A pulse on both coin lines in the same cycle is an unusable reading, and the controller discards it. The reset is synchronous and active-high.

Top module: `vend_ctrl`

## Requirements
- R1: A cycle with `rst` high puts the credit at 0 units (state code 2'b00), and `release_out` is low in the following cycle.
- R2: A lone nickel pulse moves the credit from 0 to 5 (2'b01), from 5 to 10 (2'b10), and from 10 to 15 (2'b11), at the next rising clock edge.
- R3: A lone dime pulse moves the credit from 0 to 10, from 5 to 15, and from 10 to 15; the excess is discarded, and no change output exists.
- R4: In a cycle with neither coin pulse and a credit below 15, the credit is unchanged.
- R5: `release_out` is high exactly in the cycles when the credit state is 15 units (2'b11), and never for two cycles in a row.
- R6: From the 15-unit state, the next clock edge returns the credit to 0, whatever coin pulses are present in that cycle; such coins are lost.
- R7: A cycle with both `nickel_in` and `dime_in` high leaves the credit unchanged, as if no coin arrived.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active-high |
| nickel_in | input | 1 | One-cycle pulse: a 5-unit coin was accepted |
| dime_in | input | 1 | One-cycle pulse: a 10-unit coin was accepted |
| release_out | output | 1 | High for one cycle when 15 units are reached |

## Verification
Several properties are checked on every cycle against the internal credit register:
- the hold with no coin, and the hold on a double pulse;
- the dime step from 10 to the full state;
- the forced return to zero after the full state;
- the single-cycle width of the release.

The per-step credit arithmetic and the drop of overpayment can only be seen through the timing of the release, which is the single output. This part is shown by the bench's scenarios. The bench sweeps every sequence of four coin codes from reset, and then runs a long pseudo-random stream. In both, it compares the release against a running total kept in plain integers.

// File: rtl/vend_pkg.sv
package vend_pkg;

    localparam int unsigned CREDIT_W = 2;

    typedef enum logic [CREDIT_W-1:0] {
        CR_0  = 2'b00,
        CR_5  = 2'b01,
        CR_10 = 2'b10,
        CR_15 = 2'b11
    } credit_e;

    typedef struct packed {
        logic nick;
        logic dime;
    } coin_s;

    // Behavioural step used by the table-form variant of the next-state logic
    function automatic credit_e credit_step(credit_e cur, coin_s k);
        credit_e r;
        r = cur;
        if (cur == CR_15) begin
            r = CR_0;
        end else if (k.dime) begin
            r = (cur == CR_0) ? CR_10 : CR_15;
        end else if (k.nick) begin
            case (cur)
                CR_0:    r = CR_5;
                CR_5:    r = CR_10;
                default: r = CR_15;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/vend_coin_qual.sv
module vend_coin_qual
    import vend_pkg::*;
(
    input  logic  nickel_in,
    input  logic  dime_in,
    output coin_s coin
);
    // Conflicting double pulse becomes "no coin"
    always_comb begin
        coin.nick = nickel_in & ~dime_in;
        coin.dime = dime_in & ~nickel_in;
    end
endmodule

// File: rtl/vend_credit_next.sv
module vend_credit_next
    import vend_pkg::*;
#(
    parameter bit EQN_FORM = 1'b1
) (
    input  credit_e cur,
    input  coin_s   coin,
    output credit_e nxt
);
    generate
        if (EQN_FORM) begin : g_eqn
            logic [CREDIT_W-1:0] cv;
            logic [CREDIT_W-1:0] raw;
            logic n, d;
            always_comb begin
                cv     = cur;
                n      = coin.nick;
                d      = coin.dime;
                raw[1] = d | cv[1] | (n & cv[0]);
                raw[0] = (n & cv[1]) | (n & ~cv[0]) | (cv[0] & ~n) | (d & cv[1]);
                nxt    = (cur == CR_15) ? CR_0 : credit_e'(raw);
            end
        end else begin : g_table
            always_comb nxt = credit_step(cur, coin);
        end
    endgenerate
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
    import vend_pkg::*;
#(
    parameter bit EQN_FORM = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic nickel_in,
    input  logic dime_in,
    output logic release_out
);
    coin_s   coin;
    credit_e credit_q;
    credit_e credit_d;

    vend_coin_qual u_qual (
        .nickel_in (nickel_in),
        .dime_in   (dime_in),
        .coin      (coin)
    );

    vend_credit_next #(.EQN_FORM(EQN_FORM)) u_next (
        .cur  (credit_q),
        .coin (coin),
        .nxt  (credit_d)
    );

    always_ff @(posedge clk) begin
        if (rst) credit_q <= CR_0;
        else     credit_q <= credit_d;
    end

    assign release_out = (credit_q == CR_15);

    // R4
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!nickel_in && !dime_in && credit_q != CR_15) |=> $stable(credit_q));

    // R7
    both_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (nickel_in && dime_in && credit_q != CR_15) |=> $stable(credit_q));

    // R3
    dime_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (credit_q == CR_10 && dime_in && !nickel_in) |=> (credit_q == CR_15));

    // R6
    drain_chk: assert property (@(posedge clk) disable iff (rst)
        (credit_q == CR_15) |=> (credit_q == CR_0));

    // R5
    release_once_chk: assert property (@(posedge clk) disable iff (rst)
        release_out |=> !release_out);
endmodule

// File: tb/sim_vend_ctrl.sv
module sim_vend_ctrl;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nickel_in = 1'b0;
    logic dime_in = 1'b0;
    logic release_out;

    int n_checks = 0;
    int n_fail = 0;
    int total = 0;   // bench model: running credit in units

    vend_ctrl u0 (
        .clk         (clk),
        .rst         (rst),
        .nickel_in   (nickel_in),
        .dime_in     (dime_in),
        .release_out (release_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s release actual=%b expected=%b (model total=%0d)",
                     tag, act, exp, total);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; nickel_in = 1'b0; dime_in = 1'b0;
        @(posedge clk); #1;
        rst = 1'b0;
        total = 0;
        check("R1", release_out, 1'b0);
    endtask

    // code: 0 none, 1 nickel, 2 dime, 3 both
    task automatic step(input int code);
        string tag;
        @(negedge clk);
        nickel_in = code[0];
        dime_in   = code[1];
        if (total >= 15)    begin tag = "R6"; total = 0; end
        else if (code == 3) tag = "R7";
        else if (code == 0) tag = "R4";
        else if (code == 1) begin tag = "R2"; total = total + 5; end
        else                begin tag = "R3"; total = total + 10; end
        if (total > 15) total = 15;
        @(posedge clk); #1;
        nickel_in = 1'b0; dime_in = 1'b0;
        if (total >= 15 && tag != "R6") tag = "R5";
        check(tag, release_out, total >= 15);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        // exhaustive sweep: every 4-long coin-code sequence from reset
        for (int s = 0; s < 256; s++) begin
            do_reset();
            for (int i = 0; i < 4; i++) step((s >> (2*i)) & 3);
        end
        // R1: a mid-purchase reset clears credit (10 + nickel must not release)
        do_reset();
        step(2);
        do_reset();
        step(1);
        check("R1", release_out, 1'b0);
        // R6: coins during release are lost
        do_reset();
        step(2); step(1); step(2); step(1);
        check("R6", release_out, 1'b0);
        // long pseudo-random stream
        do_reset();
        for (int i = 0; i < 3000; i++) step(int'($urandom % 4));
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL R5 watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule